// File: doc/BRIEF.md
# Test access port with scan-chain select

This block is a serial test access port controller. It runs the standard sixteen-state test state machine from a test clock and a mode-select line. It holds a 4-bit instruction and routes the data-register path to one of four places: a 32-bit identity register, a one-bit bypass stage, a 4-bit chain-select register, or one of several external scan chains. The external chains exist here only as one serial return bit per chain. For the selected chain, the block drives capture, shift and update strobes and a test-mode flag.

A chain-select instruction opens a 4-bit register on the data path. The number shifted into that register decides which external chain later data scans reach. The boundary chain, number 3, is selected again whenever the state machine passes through its reset state, the test reset pin is pulled low, or the system reset input is asserted.

Top module: `tap_chain_ctl`

## Requirements
- R1: The state machine moves on each rising edge of `tck` according to `tms`. Five rising edges with `tms` high reach the reset state from any state. `trst_n` low forces the reset state at once and sets the instruction to identity (1110).
- R2: With identity (1110) active, a data scan returns 0x0F0F0F0F, least significant bit first.
- R3: An instruction scan shifts out the fixed pattern 0001, least significant bit first. The shifted-in code takes effect only after the Update-IR state.
- R4: Bypass (1111) and every code other than 0000, 0010, 0011 and 1110, including 0001 and 0101, place a single stage between `tdi` and `tdo`. That stage captures 0, so an N-bit scan returns 0 followed by the first N-1 input bits.
- R5: The chain-select instruction (0010) places a 4-bit register on the data path. It captures the current chain number. After Update-DR, `chain_sel` is one-hot at the bit position equal to the shifted-in number.
- R6: The selected chain stays unchanged during Capture-DR, Shift-DR, Exit-DR and Pause-DR. It changes only after Update-DR.
- R7: Chain number 3 is selected after reset by `trst_n`, after the reset state is entered, and while `sys_rst_n` is low.
- R8: External test (0000) and sample (0011) route the data path to `chain_tdo` of the selected chain. They pulse that chain's `chain_capture`, `chain_shift` and `chain_update` in the Capture-DR, Shift-DR and Update-DR states. `test_mode` is high for the selected chain only, and only under 0000.
- R9: A chain number of 4 or more selects no chain: `chain_sel` and `test_mode` are zero, and chain instructions fall back to the bypass stage.
- R10: `tdo` changes only on falling edges of `tck`. `tdo_en` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sys_rst_n | input | 1 | System reset, active low; reselects the boundary chain |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_en | output | 1 | Output enable for `tdo` |
| chain_tdo | input | NCHAIN | Serial return bit of each external chain |
| chain_sel | output | NCHAIN | One-hot selected chain |
| chain_capture | output | NCHAIN | Capture strobe per chain |
| chain_shift | output | NCHAIN | Shift strobe per chain |
| chain_update | output | NCHAIN | Update strobe per chain |
| test_mode | output | NCHAIN | Test-mode flag per chain |

## Verification
The hardest case to reach is a chain-select scan stopped partway. The stimulus shifts a new chain number, moves through Exit-DR into Pause-DR, and holds there while `chain_sel` is observed unchanged. It then resumes through Exit2-DR into Update-DR. A second hard case is a chain number outside the range under external test, which must fall back silently to the bypass stage. A third is leaving a live data shift through five high `tms` cycles, which must restore both the boundary chain and the identity instruction.

// File: rtl/tap_chain_ctl.sv
module tap_chain_ctl #(
  parameter int NCHAIN = 4,
  parameter int CHW = 4,
  parameter int IDW = 32,
  parameter logic [IDW-1:0] IDVAL = 32'h0F0F0F0F,
  parameter logic [CHW-1:0] BOUND_ID = 4'd3
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              sys_rst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [NCHAIN-1:0] chain_tdo,
  output logic [NCHAIN-1:0] chain_sel,
  output logic [NCHAIN-1:0] chain_capture,
  output logic [NCHAIN-1:0] chain_shift,
  output logic [NCHAIN-1:0] chain_update,
  output logic [NCHAIN-1:0] test_mode
);
  localparam int IRW = 4;
  localparam logic [IRW-1:0] OP_EXT = 4'b0000;
  localparam logic [IRW-1:0] OP_SEL = 4'b0010;
  localparam logic [IRW-1:0] OP_SMP = 4'b0011;
  localparam logic [IRW-1:0] OP_ID  = 4'b1110;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PS_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PS_IR, EX2_IR, UPD_IR
  } tap_st_t;

  tap_st_t st, nx;
  logic [IRW-1:0] ir, ir_sh;
  logic [IDW-1:0] id_sh;
  logic [CHW-1:0] cs, cs_sh;
  logic by_sh, so, tdo_q, oe_q;

  always_comb begin
    case (st)
      TLR:     nx = tms ? TLR    : RTI;
      RTI:     nx = tms ? SEL_DR : RTI;
      SEL_DR:  nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nx = tms ? EX1_DR : SH_DR;
      SH_DR:   nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  nx = tms ? UPD_DR : PS_DR;
      PS_DR:   nx = tms ? EX2_DR : PS_DR;
      EX2_DR:  nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  nx = tms ? SEL_DR : RTI;
      SEL_IR:  nx = tms ? TLR    : CAP_IR;
      CAP_IR:  nx = tms ? EX1_IR : SH_IR;
      SH_IR:   nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  nx = tms ? UPD_IR : PS_IR;
      PS_IR:   nx = tms ? EX2_IR : PS_IR;
      EX2_IR:  nx = tms ? UPD_IR : SH_IR;
      UPD_IR:  nx = tms ? SEL_DR : RTI;
      default: nx = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else st <= nx;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir <= OP_ID;
      ir_sh <= '0;
    end else begin
      case (st)
        TLR:     ir <= OP_ID;
        CAP_IR:  ir_sh <= 4'b0001;
        SH_IR:   ir_sh <= {tdi, ir_sh[IRW-1:1]};
        UPD_IR:  ir <= ir_sh;
        default: ;
      endcase
    end

  wire is_ext = (ir == OP_EXT);
  wire is_sel = (ir == OP_SEL);
  wire is_id = (ir == OP_ID);
  wire chain_ir = is_ext || (ir == OP_SMP);
  wire chain_ok = int'(cs) < NCHAIN;
  wire cs_rst_n = trst_n & sys_rst_n;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      id_sh <= '0;
      by_sh <= 1'b0;
      cs_sh <= '0;
    end else if (st == CAP_DR) begin
      id_sh <= IDVAL;
      by_sh <= 1'b0;
      cs_sh <= cs;
    end else if (st == SH_DR) begin
      id_sh <= {tdi, id_sh[IDW-1:1]};
      by_sh <= tdi;
      cs_sh <= {tdi, cs_sh[CHW-1:1]};
    end

  always_ff @(posedge tck or negedge cs_rst_n)
    if (!cs_rst_n) cs <= BOUND_ID;
    else if (st == TLR) cs <= BOUND_ID;
    else if (st == UPD_DR && is_sel) cs <= cs_sh;

  for (genvar i = 0; i < NCHAIN; i++) begin : g_sel
    assign chain_sel[i] = chain_ok && (cs == CHW'(i));
  end

  assign chain_capture = chain_sel & {NCHAIN{chain_ir && st == CAP_DR}};
  assign chain_shift   = chain_sel & {NCHAIN{chain_ir && st == SH_DR}};
  assign chain_update  = chain_sel & {NCHAIN{chain_ir && st == UPD_DR}};
  assign test_mode     = chain_sel & {NCHAIN{is_ext}};

  wire chain_rx = |(chain_tdo & chain_sel);

  always_comb begin
    if (st == SH_IR) so = ir_sh[0];
    else if (st != SH_DR) so = 1'b0;
    else if (is_id) so = id_sh[0];
    else if (is_sel) so = cs_sh[0];
    else if (chain_ir && chain_ok) so = chain_rx;
    else so = by_sh;
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      tdo_q <= so;
      oe_q <= (st == SH_IR) || (st == SH_DR);
    end

  assign tdo = tdo_q;
  assign tdo_en = oe_q;

  a_r1_tlr_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR && tms) |=> (st == TLR));
  a_r3_ir_update_only: assert property (@(posedge tck) disable iff (!trst_n)
    (st != UPD_IR && st != TLR) |=> $stable(ir));
  a_r6_cs_update_only: assert property (@(posedge tck) disable iff (!trst_n || !sys_rst_n)
    (st != UPD_DR && st != TLR) |=> $stable(cs));
  a_r7_tlr_boundary: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR) |=> (cs == BOUND_ID));
  a_r8_tm_extest: assert property (@(posedge tck) disable iff (!trst_n)
    (|test_mode) |-> (ir == OP_EXT && $onehot0(test_mode)));
  a_r10_oe_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (st == SH_IR || st == SH_DR));
endmodule

// File: tb/tap_chain_ctl_tb.sv
module tap_chain_ctl_tb_top;
  logic tck = 1'b0, trst_n = 1'b0, sys_rst_n = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic [3:0] ctdo;
  logic tdo, tdo_en;
  logic [3:0] csel, ccap, cshf, cupd, tmode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 tck = ~tck;

  tap_chain_ctl dut_i (
    .tck(tck), .trst_n(trst_n), .sys_rst_n(sys_rst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .chain_tdo(ctdo), .chain_sel(csel),
    .chain_capture(ccap), .chain_shift(cshf), .chain_update(cupd), .test_mode(tmode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // external chains: 8-bit each, capture 0xA0|index
  logic [7:0] fc [4] = '{default: 8'h00};
  always @(posedge tck)
    for (int i = 0; i < 4; i++)
      if (ccap[i]) fc[i] <= 8'hA0 | 8'(i);
      else if (cshf[i]) fc[i] <= {tdi, fc[i][7:1]};
  always_comb for (int i = 0; i < 4; i++) ctdo[i] = fc[i][0];

  // behavioural reference
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5, S_PD = 6,
                 S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11, S_E1I = 12,
                 S_PI = 13, S_E2I = 14, S_UIR = 15;
  int ms = S_TLR, os;
  logic [3:0] mir = 4'hE, mirsh = 4'h0, mcs = 4'd3, mcsh = 4'h0;
  logic [31:0] mid = 32'h0;
  logic mby = 1'b0;

  function automatic int nxt(input int s, input logic m);
    case (s)
      S_TLR: return m ? S_TLR : S_RTI;
      S_RTI, S_UDR, S_UIR: return m ? S_SDR : S_RTI;
      S_SDR: return m ? S_SIR : S_CDR;
      S_CDR, S_HDR: return m ? S_E1D : S_HDR;
      S_E1D: return m ? S_UDR : S_PD;
      S_PD: return m ? S_E2D : S_PD;
      S_E2D: return m ? S_UDR : S_HDR;
      S_SIR: return m ? S_TLR : S_CIR;
      S_CIR, S_HIR: return m ? S_E1I : S_HIR;
      S_E1I: return m ? S_UIR : S_PI;
      S_PI: return m ? S_E2I : S_PI;
      default: return m ? S_UIR : S_HIR;
    endcase
  endfunction

  always @(posedge tck) begin
    if (trst_n) begin
      os = ms;
      ms = nxt(os, tms);
      if (os == S_TLR) begin mir = 4'hE; mcs = 4'd3; end
      if (os == S_CIR) mirsh = 4'b0001;
      if (os == S_HIR) mirsh = {tdi, mirsh[3:1]};
      if (os == S_UIR) mir = mirsh;
      if (os == S_CDR) begin mid = 32'h0F0F0F0F; mby = 1'b0; mcsh = mcs; end
      if (os == S_HDR) begin mid = {tdi, mid[31:1]}; mby = tdi; mcsh = {tdi, mcsh[3:1]}; end
      if (os == S_UDR && mir == 4'b0010) mcs = mcsh;
    end
    if (!sys_rst_n) mcs = 4'd3;
  end
  always @(negedge trst_n) begin ms = S_TLR; mir = 4'hE; mcs = 4'd3; end
  always @(negedge sys_rst_n) mcs = 4'd3;

  logic tpre;
  always @(negedge tck) begin : cmp
    logic [3:0] esel;
    logic chir, eoe, et;
    string tg;
    #3;
    if (!done) begin
      esel = (mcs < 4) ? 4'(1 << mcs) : 4'h0;
      chir = (mir == 4'b0000) || (mir == 4'b0011);
      eoe = (ms == S_HIR) || (ms == S_HDR);
      chk(tdo_en === eoe, "R10 tdo_en", 32'(tdo_en), 32'(eoe));
      chk(csel === esel, "R5 chain_sel", 32'(csel), 32'(esel));
      chk(tmode === ((mir == 4'b0000) ? esel : 4'h0), "R8 test_mode", 32'(tmode), 32'(esel));
      chk(ccap === ((chir && ms == S_CDR) ? esel : 4'h0), "R8 capture strobe", 32'(ccap), 32'(esel));
      chk(cshf === ((chir && ms == S_HDR) ? esel : 4'h0), "R8 shift strobe", 32'(cshf), 32'(esel));
      chk(cupd === ((chir && ms == S_UDR) ? esel : 4'h0), "R8 update strobe", 32'(cupd), 32'(esel));
      if (eoe) begin
        if (ms == S_HIR) begin et = mirsh[0]; tg = "R3 ir tdo"; end
        else if (mir == 4'hE) begin et = mid[0]; tg = "R2 id tdo"; end
        else if (mir == 4'b0010) begin et = mcsh[0]; tg = "R5 select tdo"; end
        else if (chir && mcs < 4) begin et = ctdo[mcs[1:0]]; tg = "R8 chain tdo"; end
        else begin et = mby; tg = "R4 bypass tdo"; end
        chk(tdo === et, tg, 32'(tdo), 32'(et));
      end
    end
    #1 tpre = tdo;
  end

  always @(posedge tck) begin
    #1;
    if (trst_n && !done) chk(tdo === tpre, "R10 tdo steady at rising edge", 32'(tdo), 32'(tpre));
  end

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    o = tdo;
  endtask

  task automatic go(input logic m);
    logic x;
    step(m, 1'b0, x);
  endtask

  task automatic ir_scan(input logic [3:0] v, output logic [3:0] cap);
    logic b;
    go(1); go(1); go(0); go(0);
    for (int k = 0; k < 4; k++) begin step(k == 3, v[k], b); cap[k] = b; end
    go(1); go(0); go(0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] v, output logic [31:0] cap, input bit hold);
    logic b;
    cap = '0;
    go(1); go(0); go(0);
    for (int k = 0; k < n; k++) begin step(k == n - 1, v[k], b); cap[k] = b; end
    if (!hold) begin go(1); go(0); go(0); end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_up();
  end

  initial begin : seq
    logic [3:0] ic;
    logic [31:0] dc;
    repeat (3) @(negedge tck);
    #2;
    chk(tdo_en === 1'b0, "R1 reset tdo_en", 32'(tdo_en), 0);
    chk(csel === 4'b1000, "R7 reset chain_sel", 32'(csel), 32'h8);
    chk(tmode === 4'h0, "R1 reset test_mode", 32'(tmode), 0);
    trst_n = 1'b1;
    go(0); go(0);
    dr_scan(32, 32'h12345678, dc, 0);
    chk(dc === 32'h0F0F0F0F, "R2 id after reset", dc, 32'h0F0F0F0F);

    ir_scan(4'hF, ic);
    chk(ic === 4'b0001, "R3 ir capture", 32'(ic), 1);
    dr_scan(8, 32'hB3, dc, 0);
    chk(dc === 32'h66, "R4 bypass 1111", dc, 32'h66);
    ir_scan(4'b0001, ic);
    dr_scan(8, 32'h5A, dc, 0);
    chk(dc === 32'hB4, "R4 bypass code 0001", dc, 32'hB4);
    ir_scan(4'b0101, ic);
    dr_scan(8, 32'hC9, dc, 0);
    chk(dc === 32'h92, "R4 bypass code 0101", dc, 32'h92);

    ir_scan(4'b0010, ic);
    dr_scan(4, 32'h1, dc, 0);
    chk(dc === 32'h3, "R5 select capture", dc, 3);
    chk(csel === 4'b0010, "R5 select chain 1", 32'(csel), 2);

    dr_scan(4, 32'h0, dc, 1);
    chk(dc === 32'h1, "R5 select capture current", dc, 1);
    go(0); go(0);
    chk(csel === 4'b0010, "R6 pause keeps chain", 32'(csel), 2);
    go(1); go(1); go(0); go(0);
    chk(csel === 4'b0001, "R6 update applies chain 0", 32'(csel), 1);

    ir_scan(4'b0000, ic);
    chk(tmode === 4'b0001, "R8 extest test_mode", 32'(tmode), 1);
    dr_scan(8, 32'h3C, dc, 0);
    chk(dc === 32'hA0, "R8 extest chain 0 data", dc, 32'hA0);

    ir_scan(4'b0010, ic);
    dr_scan(4, 32'h2, dc, 0);
    ir_scan(4'b0011, ic);
    chk(tmode === 4'h0, "R8 sample no test_mode", 32'(tmode), 0);
    chk(csel === 4'b0100, "R8 sample chain 2 selected", 32'(csel), 4);
    dr_scan(8, 32'h00, dc, 0);
    chk(dc === 32'hA2, "R8 sample chain 2 data", dc, 32'hA2);

    ir_scan(4'b0010, ic);
    dr_scan(4, 32'h9, dc, 0);
    chk(csel === 4'h0, "R9 chain 9 selects none", 32'(csel), 0);
    ir_scan(4'b0000, ic);
    chk(tmode === 4'h0, "R9 no test_mode", 32'(tmode), 0);
    dr_scan(8, 32'hE7, dc, 0);
    chk(dc === 32'hCE, "R9 falls back to bypass", dc, 32'hCE);

    sys_rst_n = 1'b0;
    go(0); go(0);
    chk(csel === 4'b1000, "R7 system reset boundary", 32'(csel), 8);
    chk(tmode === 4'b1000, "R7 boundary under extest", 32'(tmode), 8);
    sys_rst_n = 1'b1;
    go(0);

    ir_scan(4'b0010, ic);
    dr_scan(4, 32'h1, dc, 0);
    ir_scan(4'b0000, ic);
    go(1); go(0); go(0); go(0);
    repeat (7) go(1);
    chk(csel === 4'b1000, "R7 reset state boundary", 32'(csel), 8);
    chk(tmode === 4'h0, "R1 five ones restore id", 32'(tmode), 0);
    go(0); go(0);
    dr_scan(32, 32'h0, dc, 0);
    chk(dc === 32'h0F0F0F0F, "R2 id after tms reset", dc, 32'h0F0F0F0F);

    ir_scan(4'b0000, ic);
    chk(tmode === 4'b1000, "R8 extest boundary", 32'(tmode), 8);
    trst_n = 1'b0;
    #1;
    chk(tmode === 4'h0, "R1 async test reset", 32'(tmode), 0);
    chk(csel === 4'b1000, "R7 async test reset boundary", 32'(csel), 8);
    go(1);
    trst_n = 1'b1;
    go(0); go(0);
    finish_up();
  end
endmodule